// File: doc/BRIEF.md
# UART Register and Command Interface

This block is the software-visible control face of a byte-oriented UART. A host reaches it through a simple synchronous register bus with a 6-bit address. The bus can write modes, commands, transmit bytes, an interrupt mask and a two-byte baud divider. It can read status, receive bytes and interrupt status. The serial bit engine, the baud generator and the receive FIFO are separate blocks. This block hands transmit bytes to the serializer through a valid/ready pair. It pops, inspects and flushes the show-ahead receive FIFO through a count/data/pop/flush port.

The two mode registers share one address. A pointer selects which one an access uses. The first write lands in mode register A and moves the pointer to B, and a command moves it back. A single command byte packs three fields: a miscellaneous action, a transmitter action and a receiver action. All three take effect in the same cycle, applied in that order. One level-sensitive interrupt line is raised when any unmasked interrupt status bit is set. The receive interrupt source can be switched between "data present" and "FIFO full".

Top module: `uart_csr_front`

## Requirements
- R1: Reset (synchronous, active high) leaves tx_valid, irq, rx_enable and bus_rdata low. The status register reads 0x08 (transmitter empty only). Both mode registers, the interrupt status and the interrupt mask read zero.
- R2: Offset 0x00 is shared by two mode registers through a pointer. A write stores into the register the pointer selects and then sets the pointer to B. A read returns the selected register. Command miscellaneous code 1 returns the pointer to A.
- R3: Status at offset 0x04 has these bits: bit0 = FIFO count nonzero, bit1 = FIFO count equals its depth, bit2 = transmitter enabled, bit3 = transmitter empty, bits 7:4 = 0. Writes to 0x04 change nothing.
- R4: A write to offset 0x08 is a command with three fields. Bits 1:0 are the receiver field and bits 3:2 the transmitter field, each coded 0 no-op, 1 enable, 2 disable, 3 ignored. Bits 6:4 are the miscellaneous field. All three fields apply in one cycle in the order miscellaneous, transmitter, receiver. Miscellaneous codes 0, 4, 6 and 7 do nothing.
- R5: Miscellaneous code 2 clears rx_enable and drives rxf_flush high for the cycle of the command write.
- R6: Miscellaneous code 3 disables the transmitter, sets transmitter-empty and discards any byte not yet accepted, so that byte is never presented on tx_valid.
- R7: A write to offset 0x0C latches the byte and clears transmitter-empty. tx_valid is high while the transmitter is enabled and not empty, and tx_data is held stable while tx_valid waits. Transmitter-empty is set on the cycle tx_valid and tx_ready are both high. A byte written while the transmitter is disabled waits until it is enabled.
- R8: A read of offset 0x0C with a nonzero FIFO count pulses rxf_pop in that cycle and returns the FIFO head. With a zero count it returns 0 and does not pop.
- R9: Interrupt status at offset 0x14 has these bits: bit0 = transmitter enabled; bit1 = FIFO full when mode register A bit 6 is set, otherwise FIFO count nonzero; bit2 = break-change flag; other bits 0.
- R10: A brk_evt pulse sets the break-change flag. Miscellaneous code 5 clears it, and a simultaneous event wins.
- R11: A write to offset 0x14 sets the interrupt mask. irq is high one cycle after (interrupt status AND mask) is nonzero.
- R12: Offsets 0x18 and 0x1C are read/write divider bytes driving baud_div as {0x18 byte, 0x1C byte}. Offsets 0x08, 0x10 and every other unlisted offset read 0. Read data appears on bus_rdata the cycle after the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_valid | output | 1 | Transmit byte offered to the serializer |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serializer accepts the byte |
| rxf_pop | output | 1 | Remove the head of the receive FIFO |
| rxf_data | input | 8 | Receive FIFO head (show-ahead) |
| rxf_count | input | CNT_W | Receive FIFO occupancy |
| rxf_flush | output | 1 | Empty the receive FIFO |
| brk_evt | input | 1 | Break-change event pulse from the receiver |
| rx_enable | output | 1 | Receiver enable to the serial engine |
| baud_div | output | 16 | Divider value for the baud generator |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach are those where a byte is latched but must not leave. One is a byte written while the transmitter is disabled. The other is a pending byte caught by a transmitter reset. The bench holds tx_ready low, writes the byte, then issues the disable or reset command. It then lets the serializer accept freely and counts bytes actually handed over, so a leaked byte shows up as an extra entry. Command bytes that combine a reset with an enable in the same write are used to expose the field ordering. The receive-interrupt selection is switched while the FIFO model holds one byte and again when it holds a full load.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;

  // Register offsets
  localparam logic [ADDR_W-1:0] OFS_MODE = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_DATA = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_ISR  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_DIVH = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_DIVL = 6'h1C;

  // Mode register A bit choosing the receive interrupt source
  localparam int MR_RXSEL = 6;

  typedef enum logic [2:0] {
    MISC_NOP     = 3'd0,
    MISC_PTR_RST = 3'd1,
    MISC_RX_RST  = 3'd2,
    MISC_TX_RST  = 3'd3,
    MISC_ERR_RST = 3'd4,
    MISC_BRK_CLR = 3'd5,
    MISC_BRK_ON  = 3'd6,
    MISC_BRK_OFF = 3'd7
  } misc_e;

  typedef enum logic [1:0] {
    DIR_NOP = 2'd0,
    DIR_EN  = 2'd1,
    DIR_DIS = 2'd2,
    DIR_RSV = 2'd3
  } dir_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic brk_clr;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_csr_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [6:0] cmd_byte,
  output cmd_t       cmd
);

  misc_e misc_f;
  dir_e  tx_f;
  dir_e  rx_f;

  assign misc_f = misc_e'(cmd_byte[6:4]);
  assign tx_f   = dir_e'(cmd_byte[3:2]);
  assign rx_f   = dir_e'(cmd_byte[1:0]);

  always_comb begin
    cmd = '0;
    if (cmd_wr) begin
      case (misc_f)
        MISC_PTR_RST: cmd.ptr_rst = 1'b1;
        MISC_RX_RST:  cmd.rx_rst  = 1'b1;
        MISC_TX_RST:  cmd.tx_rst  = 1'b1;
        MISC_BRK_CLR: cmd.brk_clr = 1'b1;
        default:      ;
      endcase
      cmd.tx_on  = (tx_f == DIR_EN);
      cmd.tx_off = (tx_f == DIR_DIS);
      cmd.rx_on  = (rx_f == DIR_EN);
      cmd.rx_off = (rx_f == DIR_DIS);
    end
  end

endmodule

// File: rtl/uart_mode_bank.sv
module uart_mode_bank #(
  parameter int NUM_MODE = 2,
  parameter int W        = 8,
  parameter int SEL_BIT  = 6,
  localparam int PW      = (NUM_MODE > 1) ? $clog2(NUM_MODE) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         ptr_rst,
  output logic [W-1:0] rd_val,
  output logic         rx_sel
);

  logic [NUM_MODE-1:0][W-1:0] mode_q;
  logic [PW-1:0]              ptr_q;

  for (genvar g = 0; g < NUM_MODE; g++) begin : g_mode
    always_ff @(posedge clk) begin
      if (rst)                             mode_q[g] <= '0;
      else if (wr && (ptr_q == PW'(g)))    mode_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                       ptr_q <= '0;
    else if (ptr_rst)                              ptr_q <= '0;
    else if (wr && (ptr_q != PW'(NUM_MODE - 1)))   ptr_q <= ptr_q + 1'b1;
  end

  assign rd_val = mode_q[ptr_q];
  assign rx_sel = mode_q[0][SEL_BIT];

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         tx_rst,
  input  logic         tx_on,
  input  logic         tx_off,
  input  logic         tx_ready,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  output logic         tx_enabled,
  output logic         tx_empty
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_enabled <= 1'b0;
      tx_empty   <= 1'b1;
      tx_data    <= '0;
    end else begin
      if (tx_valid && tx_ready) tx_empty <= 1'b1;
      if (wr) begin
        tx_empty <= 1'b0;
        tx_data  <= wdata;
      end
      // miscellaneous field first, transmitter field second
      if (tx_rst) begin
        tx_enabled <= 1'b0;
        tx_empty   <= 1'b1;
      end
      if (tx_on)       tx_enabled <= 1'b1;
      else if (tx_off) tx_enabled <= 1'b0;
    end
  end

  assign tx_valid = tx_enabled && !tx_empty;

endmodule

// File: rtl/uart_csr_front.sv
module uart_csr_front
  import uart_csr_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int NUM_MODE   = 2,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              rxf_pop,
  input  logic [DATA_W-1:0] rxf_data,
  input  logic [CNT_W-1:0]  rxf_count,
  output logic              rxf_flush,
  input  logic              brk_evt,
  output logic              rx_enable,
  output logic [2*DATA_W-1:0] baud_div,
  output logic              irq
);

  logic wr_hit, rd_hit;
  assign wr_hit = bus_sel &&  bus_we;
  assign rd_hit = bus_sel && !bus_we;

  cmd_t cmd;
  uart_cmd_decode u_dec (
    .cmd_wr   (wr_hit && (bus_addr == OFS_CMD)),
    .cmd_byte (bus_wdata[6:0]),
    .cmd      (cmd)
  );

  logic [DATA_W-1:0] mode_rd;
  logic              rx_sel;
  uart_mode_bank #(.NUM_MODE(NUM_MODE), .W(DATA_W), .SEL_BIT(MR_RXSEL)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_hit && (bus_addr == OFS_MODE)),
    .wdata   (bus_wdata),
    .ptr_rst (cmd.ptr_rst),
    .rd_val  (mode_rd),
    .rx_sel  (rx_sel)
  );

  logic tx_enabled, tx_empty;
  uart_tx_hold #(.W(DATA_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .wr         (wr_hit && (bus_addr == OFS_DATA)),
    .wdata      (bus_wdata),
    .tx_rst     (cmd.tx_rst),
    .tx_on      (cmd.tx_on),
    .tx_off     (cmd.tx_off),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_enabled (tx_enabled),
    .tx_empty   (tx_empty)
  );

  // Receive side
  logic rx_rdy, rx_full;
  assign rx_rdy  = (rxf_count != '0);
  assign rx_full = (rxf_count == CNT_W'(FIFO_DEPTH));

  always_ff @(posedge clk) begin
    if (rst) rx_enable <= 1'b0;
    else begin
      if (cmd.rx_rst)     rx_enable <= 1'b0;
      if (cmd.rx_on)      rx_enable <= 1'b1;
      else if (cmd.rx_off) rx_enable <= 1'b0;
    end
  end

  assign rxf_flush = cmd.rx_rst;
  assign rxf_pop   = rd_hit && (bus_addr == OFS_DATA) && rx_rdy;

  // Break-change flag
  logic brk_q;
  always_ff @(posedge clk) begin
    if (rst)              brk_q <= 1'b0;
    else if (brk_evt)     brk_q <= 1'b1;
    else if (cmd.brk_clr) brk_q <= 1'b0;
  end

  // Status and interrupt status
  logic [DATA_W-1:0] status_v, isr_vec;
  assign status_v = {4'b0000, tx_empty, tx_enabled, rx_full, rx_rdy};
  assign isr_vec  = {5'b00000, brk_q, (rx_sel ? rx_full : rx_rdy), tx_enabled};

  // Mask and divider registers
  logic [DATA_W-1:0] imr_q, div_hi_q, div_lo_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      imr_q    <= '0;
      div_hi_q <= '0;
      div_lo_q <= '0;
    end else if (wr_hit) begin
      case (bus_addr)
        OFS_ISR:  imr_q    <= bus_wdata;
        OFS_DIVH: div_hi_q <= bus_wdata;
        OFS_DIVL: div_lo_q <= bus_wdata;
        default:  ;
      endcase
    end
  end
  assign baud_div = {div_hi_q, div_lo_q};

  // Registered read data
  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_hit) begin
      case (bus_addr)
        OFS_MODE: bus_rdata <= mode_rd;
        OFS_STAT: bus_rdata <= status_v;
        OFS_DATA: bus_rdata <= rx_rdy ? rxf_data : '0;
        OFS_ISR:  bus_rdata <= isr_vec;
        OFS_DIVH: bus_rdata <= div_hi_q;
        OFS_DIVL: bus_rdata <= div_lo_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // Registered interrupt line
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(isr_vec & imr_q);
  end

endmodule

// File: rtl/uart_csr_front_chk.sv
module uart_csr_front_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_sel,
  input logic       bus_we,
  input logic [5:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       rxf_pop,
  input logic [7:0] rxf_data,
  input logic       rxf_flush,
  input logic       rx_enable,
  input logic       irq,
  input logic [7:0] imr_q
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!tx_valid && !irq && bus_rdata == 8'h00));

  assert_tx_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == 6'h08 && bus_wdata[6:4] == 3'd3) |=> !tx_valid);

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !(bus_sel && bus_we)) |=> (tx_valid && $stable(tx_data)));

  assert_flush_off_R5: assert property (@(posedge clk) disable iff (rst)
    (rxf_flush && bus_wdata[1:0] != 2'd1) |=> !rx_enable);

  assert_pop_data_R8: assert property (@(posedge clk) disable iff (rst)
    rxf_pop |=> (bus_rdata == $past(rxf_data)));

  assert_mask_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (imr_q == 8'h00) |=> !irq);

endmodule

bind uart_csr_front uart_csr_front_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .rxf_pop   (rxf_pop),
  .rxf_data  (rxf_data),
  .rxf_flush (rxf_flush),
  .rx_enable (rx_enable),
  .irq       (irq),
  .imr_q     (imr_q)
);

// File: tb/tb_uart_csr_front.sv
module tb_uart_csr_front;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        rxf_pop;
  logic [7:0]  rxf_data;
  logic [2:0]  rxf_count;
  logic        rxf_flush;
  logic        brk_evt = 1'b0;
  logic        rx_enable;
  logic [15:0] baud_div;
  logic        irq;

  always #4 clk = ~clk;

  uart_csr_front dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rxf_pop(rxf_pop), .rxf_data(rxf_data), .rxf_count(rxf_count),
    .rxf_flush(rxf_flush), .brk_evt(brk_evt), .rx_enable(rx_enable),
    .baud_div(baud_div), .irq(irq)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Scoreboard queues for read data
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_pend = 1'b0;

  // Receive FIFO model (external block), depth 4
  logic [7:0] fm [4];
  logic [2:0] fcnt = '0;
  logic       push_req = 1'b0;
  logic [7:0] push_val = '0;
  assign rxf_data  = fm[0];
  assign rxf_count = fcnt;

  initial for (int i = 0; i < 4; i++) fm[i] = 8'h00;

  always @(posedge clk) begin
    if (rst || rxf_flush) fcnt <= '0;
    else if (push_req && fcnt < 3'd4) begin
      fm[fcnt[1:0]] <= push_val;
      fcnt <= fcnt + 3'd1;
    end else if (rxf_pop) begin
      for (int i = 0; i < 3; i++) fm[i] <= fm[i+1];
      fcnt <= fcnt - 3'd1;
    end
  end

  // Transmit log, pop and flush counters
  logic [7:0] tx_log[$];
  int pop_cnt = 0;
  int flush_cnt = 0;
  always @(posedge clk) begin
    if (!rst) begin
      if (tx_valid && tx_ready) tx_log.push_back(tx_data);
      if (rxf_pop)   pop_cnt++;
      if (rxf_flush) flush_cnt++;
    end
  end

  // Monitor: compare read data against the scoreboard
  always @(posedge clk) rd_pend <= bus_sel && !bus_we && !rst;

  always @(negedge clk) begin
    if (rd_pend) begin
      logic [7:0] e;
      string t;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL read with no expectation act=%0h", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s act=%0h exp=%0h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk);
    push_req = 1'b1; push_val = v;
    @(negedge clk);
    push_req = 1'b0;
  endtask

  task automatic brk_pulse();
    @(negedge clk);
    brk_evt = 1'b1;
    @(negedge clk);
    brk_evt = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int fl0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(rx_enable == 0, "R1 rx_enable", rx_enable, 0);
    rd(6'h04, 8'h08, "R1 status");
    rd(6'h00, 8'h00, "R1 mode");
    rd(6'h14, 8'h00, "R1 isr");

    // R2 mode pointer
    wr(6'h00, 8'h13);
    wr(6'h00, 8'h27);
    rd(6'h00, 8'h27, "R2 pointer at B");
    rd(6'h00, 8'h27, "R2 pointer stays at B");
    wr(6'h08, 8'h10);
    rd(6'h00, 8'h13, "R2 pointer reset to A");
    wr(6'h00, 8'h00);
    rd(6'h00, 8'h27, "R2 advance after write");

    // R3 status write ignored, R12 dividers and unlisted offsets
    wr(6'h04, 8'hFF);
    rd(6'h04, 8'h08, "R3 status write ignored");
    wr(6'h18, 8'hA5);
    wr(6'h1C, 8'h3C);
    rd(6'h18, 8'hA5, "R12 div hi");
    rd(6'h1C, 8'h3C, "R12 div lo");
    chk(baud_div == 16'hA53C, "R12 baud_div", baud_div, 16'hA53C);
    rd(6'h10, 8'h00, "R12 offset 0x10");
    rd(6'h24, 8'h00, "R12 offset 0x24");
    rd(6'h08, 8'h00, "R12 command reads zero");

    // R7 transmit path
    wr(6'h08, 8'h04);
    rd(6'h04, 8'h0C, "R3 tx enabled");
    chk(tx_valid == 0, "R7 no valid when empty", tx_valid, 0);
    wr(6'h0C, 8'h5A);
    chk(tx_valid == 1 && tx_data == 8'h5A, "R7 valid with byte", tx_data, 8'h5A);
    rd(6'h04, 8'h04, "R7 empty cleared");
    chk(tx_valid == 1, "R7 valid waits for ready", tx_valid, 1);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk(tx_log.size() == 1, "R7 one byte accepted", tx_log.size(), 1);
    chk(tx_log.size() > 0 && tx_log[0] == 8'h5A, "R7 accepted data", tx_log.size() > 0 ? tx_log[0] : 0, 8'h5A);
    chk(tx_valid == 0, "R7 valid drops after accept", tx_valid, 0);
    rd(6'h04, 8'h0C, "R7 empty set on accept");

    wr(6'h08, 8'h08);
    rd(6'h04, 8'h08, "R7 tx disabled");
    wr(6'h0C, 8'h77);
    rd(6'h04, 8'h00, "R7 pending while disabled");
    chk(tx_valid == 0, "R7 no valid while disabled", tx_valid, 0);
    tx_ready = 1'b1;
    idle(3);
    chk(tx_log.size() == 1, "R7 held while disabled", tx_log.size(), 1);
    wr(6'h08, 8'h04);
    idle(2);
    chk(tx_log.size() == 2, "R7 sent after enable", tx_log.size(), 2);
    chk(tx_log.size() == 2 && tx_log[1] == 8'h77, "R7 second byte", tx_log.size() == 2 ? tx_log[1] : 0, 8'h77);
    rd(6'h04, 8'h0C, "R7 empty again");

    // R6 transmitter reset discards pending byte
    tx_ready = 1'b0;
    wr(6'h0C, 8'h99);
    chk(tx_valid == 1, "R6 pending before reset", tx_valid, 1);
    wr(6'h08, 8'h30);
    chk(tx_valid == 0, "R6 valid cleared", tx_valid, 0);
    rd(6'h04, 8'h08, "R6 status after reset");
    tx_ready = 1'b1;
    wr(6'h08, 8'h04);
    idle(3);
    chk(tx_log.size() == 2, "R6 byte discarded", tx_log.size(), 2);
    rd(6'h04, 8'h0C, "R6 re-enabled empty");

    // R4 ordering, reserved and no-op codes
    wr(6'h08, 8'h34);
    rd(6'h04, 8'h0C, "R4 reset then enable");
    wr(6'h08, 8'h0C);
    rd(6'h04, 8'h0C, "R4 reserved tx code ignored");
    wr(6'h08, 8'h40);
    rd(6'h04, 8'h0C, "R4 misc code 4 no-op");
    wr(6'h08, 8'h70);
    rd(6'h04, 8'h0C, "R4 misc code 7 no-op");

    // R8 receive data
    push(8'h11); push(8'h22); push(8'h33);
    rd(6'h04, 8'h0D, "R3 rx ready");
    push(8'h44);
    rd(6'h04, 8'h0F, "R3 fifo full");
    rd(6'h0C, 8'h11, "R8 pop 1");
    rd(6'h0C, 8'h22, "R8 pop 2");
    rd(6'h0C, 8'h33, "R8 pop 3");
    rd(6'h0C, 8'h44, "R8 pop 4");
    chk(pop_cnt == 4, "R8 pop count", pop_cnt, 4);
    rd(6'h0C, 8'h00, "R8 empty read zero");
    idle(1);
    chk(pop_cnt == 4, "R8 no pop when empty", pop_cnt, 4);
    rd(6'h04, 8'h0C, "R8 status empty");

    // R9 interrupt status and source select
    rd(6'h14, 8'h01, "R9 tx bit");
    push(8'hAA);
    rd(6'h14, 8'h03, "R9 rx ready source");
    wr(6'h08, 8'h10);
    wr(6'h00, 8'h40);
    rd(6'h14, 8'h01, "R9 full source not full");
    push(8'hBB); push(8'hCC); push(8'hDD);
    rd(6'h14, 8'h03, "R9 full source full");
    rd(6'h04, 8'h0F, "R9 status full");

    // R5 receiver reset, R4 receiver field
    wr(6'h08, 8'h01);
    chk(rx_enable == 1, "R4 rx enable", rx_enable, 1);
    wr(6'h08, 8'h03);
    chk(rx_enable == 1, "R4 reserved rx code ignored", rx_enable, 1);
    fl0 = flush_cnt;
    wr(6'h08, 8'h20);
    chk(rx_enable == 0, "R5 rx disabled", rx_enable, 0);
    chk(flush_cnt == fl0 + 1, "R5 flush pulse", flush_cnt, fl0 + 1);
    rd(6'h04, 8'h0C, "R5 status after flush");
    rd(6'h14, 8'h01, "R5 isr after flush");
    wr(6'h08, 8'h21);
    chk(rx_enable == 1, "R4 rx reset then enable", rx_enable, 1);
    chk(flush_cnt == fl0 + 2, "R5 second flush", flush_cnt, fl0 + 2);
    wr(6'h08, 8'h02);
    chk(rx_enable == 0, "R4 rx disable", rx_enable, 0);

    // R10 break-change flag
    brk_pulse();
    rd(6'h14, 8'h05, "R10 break set");
    wr(6'h08, 8'h40);
    rd(6'h14, 8'h05, "R10 misc 4 keeps break");
    wr(6'h08, 8'h50);
    rd(6'h14, 8'h01, "R10 break cleared");

    // R11 interrupt line
    chk(irq == 0, "R11 mask zero", irq, 0);
    wr(6'h14, 8'h04);
    idle(1);
    chk(irq == 0, "R11 masked source clear", irq, 0);
    brk_pulse();
    idle(1);
    chk(irq == 1, "R11 break unmasked", irq, 1);
    rd(6'h14, 8'h05, "R11 mask write leaves isr");
    wr(6'h08, 8'h50);
    idle(1);
    chk(irq == 0, "R11 irq drops", irq, 0);
    wr(6'h14, 8'h01);
    idle(1);
    chk(irq == 1, "R11 tx source", irq, 1);
    wr(6'h08, 8'h08);
    idle(1);
    chk(irq == 0, "R11 tx disabled", irq, 0);

    idle(3);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule